// File: doc/BRIEF.md
# Busy-Gated Trigger Forwarder with Delayed Stop

This block sits between a global trigger source and a crate of readout digitizers. It receives the global trigger pulse and one busy flag, which is the OR of the busy lines of every digitizer. It forwards the trigger as a reference (T0) pulse only while no digitizer is busy. Any trigger that meets a busy system is suppressed, so every digitizer records the same set of reference pulses and the same event number.

Both inputs are asynchronous and pass through a synchronizer. The forward/veto decision is taken on the clock cycle where the synchronized trigger rises. If busy is high at that moment, the whole pulse is blocked, even if busy clears before the trigger ends. If busy rises while a pulse is being forwarded, the pulse is cut short and does not return.

An accepted trigger can also open an acquisition window. When it does, the block issues a common-stop pulse to the digitizers a fixed number of cycles later. In the first cycle of that common stop it issues a one-cycle latch-stop pulse to the event-number latch. Accepted triggers that arrive inside an open window still produce T0 but no second stop. All delays are counted in system clock cycles. The defaults assume a 50 MHz clock: a 300-cycle stop delay (6 µs), an 800-cycle window (16 µs) and a 5-cycle common-stop pulse.

Top module: `trig_veto_fwd`

## Requirements
- R1: A synchronous active-high reset clears the synchronizers, the veto flag and all counters. `t0_o`, `cstop_o` and `lstop_o` are low while reset is sampled high.
- R2: While busy stays low, `t0_o` reproduces the trigger pulse with a latency of 3 clock edges. That is two synchronizer flops plus one output register, and the busy path has the same latency.
- R3: If the synchronized busy is high in the cycle where the synchronized trigger rises, `t0_o` stays low for the whole pulse. This holds even when busy falls before the trigger ends.
- R4: If busy rises during a forwarded pulse, `t0_o` falls with the same 3-edge latency. It stays low until the trigger falls, even if busy clears in between.
- R5: In a burst, each trigger pulse is judged on its own leading edge. Pulses that start while busy is high are suppressed, and pulses that start after busy has returned low are forwarded. `t0_o` only ever rises on a trigger leading edge.
- R6: A trigger accepted while no window is open opens one. `cstop_o` then rises exactly STOP_DELAY (default 300) cycles after the corresponding rise of `t0_o` and stays high for STOP_WIDTH (default 5) cycles.
- R7: `lstop_o` is high for exactly one cycle, and that cycle is the first cycle of each `cstop_o` pulse.
- R8: A window lasts WINDOW_LEN (default 800) cycles, counted from the `t0_o` rise that opened it. An accepted trigger whose `t0_o` rise comes fewer than WINDOW_LEN cycles after that point is forwarded but starts no stop. An accepted trigger at WINDOW_LEN cycles or later opens a new window.
- R9: A vetoed trigger opens no window and produces no `cstop_o` or `lstop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Global trigger pulse, asynchronous |
| busy_i | input | 1 | Combined busy flag of all digitizers, asynchronous |
| t0_o | output | 1 | Reference trigger pulse to the digitizers |
| cstop_o | output | 1 | Common-stop pulse, delayed after an accepted trigger |
| lstop_o | output | 1 | One-cycle stop pulse to the event-number latch |

## Verification
The assertions assume reset is held for at least two cycles, so that two-deep past values are defined. They also assume that each trigger pulse is separated from the next by at least one low cycle, so that every leading edge is seen by the synchronizer. The stimulus always releases reset after several cycles and drives both inputs only on falling clock edges. Random trigger pulses are 1 to 20 cycles long with low gaps of at least one cycle. Busy toggles freely inside and outside the pulses. The directed cases include triggers spaced exactly 799 and 800 cycles apart.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
  // Bit positions inside the synchronized input vector
  localparam int TRIG_BIT = 1;
  localparam int BUSY_BIT = 0;
  localparam int IN_BITS  = 2;

  // Width of a down-counter that must hold values 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tvf_sync.sv
module tvf_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= '0;
        else       stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= '0;
        else       stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tvf_gate.sv
module tvf_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_s_i,
  input  logic busy_s_i,
  output logic t0_o,
  output logic accept_o
);
  logic trig_q;
  logic veto_q;
  logic lead;

  assign lead     = trig_s_i & ~trig_q;
  // veto_q is always clear on a leading edge, so only busy decides here
  assign accept_o = lead & ~busy_s_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      trig_q <= 1'b0;
      veto_q <= 1'b0;
      t0_o   <= 1'b0;
    end else begin
      trig_q <= trig_s_i;
      // once busy is seen inside a pulse, the rest of that pulse stays blocked
      veto_q <= trig_s_i ? (veto_q | busy_s_i) : 1'b0;
      t0_o   <= trig_s_i & ~veto_q & ~busy_s_i;
    end
  end
endmodule

// File: rtl/tvf_stop_sched.sv
module tvf_stop_sched #(
  parameter int STOP_DELAY = 300,
  parameter int WINDOW_LEN = 800,
  parameter int STOP_WIDTH = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic accept_i,
  output logic cstop_o,
  output logic lstop_o
);
  import tvf_pkg::*;

  localparam int DW = cnt_w(STOP_DELAY);
  localparam int WW = cnt_w(WINDOW_LEN);
  localparam int SW = cnt_w(STOP_WIDTH);
  localparam logic [DW-1:0] DLY_LAST = DW'(STOP_DELAY - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_LEN - 1);
  localparam logic [SW-1:0] PLS_LAST = SW'(STOP_WIDTH - 1);

  logic          win_act;
  logic [WW-1:0] win_cnt;
  logic          dly_run;
  logic [DW-1:0] dly_cnt;
  logic [SW-1:0] pls_cnt;
  logic          win_free;
  logic          open;
  logic          fire;

  assign win_free = ~win_act | (win_cnt == '0);
  assign open     = accept_i & win_free;
  assign fire     = dly_run & (dly_cnt == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_act <= 1'b0;
      win_cnt <= '0;
      dly_run <= 1'b0;
      dly_cnt <= '0;
    end else if (open) begin
      win_act <= 1'b1;
      win_cnt <= WIN_LAST;
      dly_run <= 1'b1;
      dly_cnt <= DLY_LAST;
    end else begin
      if (win_act) begin
        if (win_cnt == '0) win_act <= 1'b0;
        else               win_cnt <= win_cnt - 1'b1;
      end
      if (dly_run) begin
        if (dly_cnt == '0) dly_run <= 1'b0;
        else               dly_cnt <= dly_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cstop_o <= 1'b0;
      lstop_o <= 1'b0;
      pls_cnt <= '0;
    end else begin
      lstop_o <= fire;
      if (fire) begin
        cstop_o <= 1'b1;
        pls_cnt <= PLS_LAST;
      end else if (cstop_o) begin
        if (pls_cnt == '0) cstop_o <= 1'b0;
        else               pls_cnt <= pls_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_veto_fwd.sv
module trig_veto_fwd #(
  parameter int SYNC_STAGES = 2,
  parameter int STOP_DELAY  = 300,
  parameter int WINDOW_LEN  = 800,
  parameter int STOP_WIDTH  = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  input  logic busy_i,
  output logic t0_o,
  output logic cstop_o,
  output logic lstop_o
);
  import tvf_pkg::*;

  logic [IN_BITS-1:0] raw;
  logic [IN_BITS-1:0] synced;
  logic               trig_s;
  logic               busy_s;
  logic               accept;

  assign raw[TRIG_BIT] = trig_i;
  assign raw[BUSY_BIT] = busy_i;
  assign trig_s = synced[TRIG_BIT];
  assign busy_s = synced[BUSY_BIT];

  tvf_sync #(.STAGES(SYNC_STAGES), .WIDTH(IN_BITS)) sync_i (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(raw), .q_o(synced)
  );

  tvf_gate gate_i (
    .clk_i(clk_i), .rst_i(rst_i), .trig_s_i(trig_s), .busy_s_i(busy_s),
    .t0_o(t0_o), .accept_o(accept)
  );

  tvf_stop_sched #(
    .STOP_DELAY(STOP_DELAY), .WINDOW_LEN(WINDOW_LEN), .STOP_WIDTH(STOP_WIDTH)
  ) sched_i (
    .clk_i(clk_i), .rst_i(rst_i), .accept_i(accept),
    .cstop_o(cstop_o), .lstop_o(lstop_o)
  );
endmodule

// File: rtl/trig_veto_fwd_chk.sv
module trig_veto_fwd_chk #(
  parameter int STOP_WIDTH = 5
) (
  input logic clk_i,
  input logic rst_i,
  input logic trig_s,
  input logic t0_o,
  input logic cstop_o,
  input logic lstop_o
);
  int cs_run;

  always_ff @(posedge clk_i) begin
    if (rst_i)        cs_run <= 0;
    else if (cstop_o) cs_run <= (cs_run > STOP_WIDTH) ? cs_run : cs_run + 1;
    else              cs_run <= 0;
  end

  AST_T0_AT_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(t0_o) |-> ($past(trig_s) && !$past(trig_s, 2))); // R5
  AST_NO_RESUME: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(t0_o) && trig_s && $past(trig_s)) |=> !t0_o); // R4
  AST_LSTOP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    lstop_o |=> !lstop_o); // R7
  AST_LSTOP_WITH_CSTOP: assert property (@(posedge clk_i) disable iff (rst_i)
    lstop_o |-> (cstop_o && !$past(cstop_o))); // R7
  AST_CSTOP_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    cs_run <= STOP_WIDTH); // R6
endmodule

bind trig_veto_fwd trig_veto_fwd_chk #(.STOP_WIDTH(STOP_WIDTH)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .trig_s(trig_s),
  .t0_o(t0_o), .cstop_o(cstop_o), .lstop_o(lstop_o)
);

// File: tb/trig_veto_fwd_tb_top.sv
module trig_veto_fwd_tb_top;
  localparam int DLY = 300;
  localparam int WIN = 800;
  localparam int SWD = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic busy = 1'b0;
  logic t0, cstop, lstop;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  trig_veto_fwd dut_i (
    .clk_i(clk), .rst_i(rst), .trig_i(trig), .busy_i(busy),
    .t0_o(t0), .cstop_o(cstop), .lstop_o(lstop)
  );

  // ---------------- reference model, advanced on each rising edge -------
  longint cyc = 0;
  logic s0t, s1t, s0b, s1b, mv, mprev, have_open;
  longint last_open;
  logic e_t0 = 1'b0, e_cs = 1'b0, e_ls = 1'b0;

  always @(posedge clk) begin
    logic tr, bz, acc;
    cyc = cyc + 1;
    if (rst) begin
      s0t = 0; s1t = 0; s0b = 0; s1b = 0; mv = 0; mprev = 0;
      have_open = 0; last_open = 0;
      e_t0 = 0; e_cs = 0; e_ls = 0;
    end else begin
      tr = s1t; bz = s1b;
      e_t0 = tr & !mv & !bz;
      acc  = tr & !mprev & !bz;
      if (acc && (!have_open || (cyc - last_open) >= WIN)) begin
        have_open = 1; last_open = cyc;
      end
      mv = tr ? (mv | bz) : 1'b0;
      mprev = tr;
      s1t = s0t; s0t = trig; s1b = s0b; s0b = busy;
      e_cs = have_open && cyc >= last_open + DLY && cyc < last_open + DLY + SWD;
      e_ls = have_open && cyc == last_open + DLY;
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, what, cyc, got, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input longint got, input longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // ---------------- per-cycle comparison and measurement -----------------
  int t0_hi, t0_rises, cs_hi, cs_rises, ls_hi;
  longint t0_rise_at, cs_rise_at, ls_at;
  logic t0_prev = 1'b0, cs_prev = 1'b0;

  always @(negedge clk) begin
    chk(cur_req, "t0_o", t0, e_t0);
    chk(cur_req == "R7" ? "R7" : "R6", "cstop_o", cstop, e_cs);
    chk("R7", "lstop_o", lstop, e_ls);
    if (t0) t0_hi++;
    if (t0 && !t0_prev) begin t0_rises++; t0_rise_at = cyc; end
    if (cstop) cs_hi++;
    if (cstop && !cs_prev) begin cs_rises++; cs_rise_at = cyc; end
    if (lstop) begin ls_hi++; ls_at = cyc; end
    t0_prev = t0; cs_prev = cstop;
  end

  task automatic clr_meas();
    @(posedge clk);
    t0_hi = 0; t0_rises = 0; cs_hi = 0; cs_rises = 0; ls_hi = 0;
    t0_rise_at = 0; cs_rise_at = 0; ls_at = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // trigger of len cycles; busy goes high at offset b_on and low at b_off (-1 = unchanged)
  task automatic pulse(input int len, input int b_on, input int b_off);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == b_on)  busy = 1'b1;
      if (i == b_off) busy = 1'b0;
      trig = 1'b1;
    end
    @(negedge clk);
    trig = 1'b0;
  endtask

  // ---------------- watchdog ---------------------------------------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------------------------------------
  initial begin
    void'($urandom(32'd1996));
    cur_req = "R1";
    wait_cyc(5);
    chk("R1", "t0_o in reset", t0, 1'b0);
    chk("R1", "cstop_o in reset", cstop, 1'b0);
    chk("R1", "lstop_o in reset", lstop, 1'b0);
    rst = 1'b0;
    wait_cyc(5);

    // R2 + R6 + R7: clean trigger, busy low
    cur_req = "R2";
    clr_meas();
    pulse(10, -1, -1);
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R2", "forwarded width", t0_hi, 10);
    chk_int("R6", "stop delay", cs_rise_at - t0_rise_at, DLY);
    chk_int("R6", "stop width", cs_hi, SWD);
    chk_int("R7", "latch stop count", ls_hi, 1);
    chk_int("R7", "latch stop cycle", ls_at, cs_rise_at);

    // R3 + R9: busy high throughout
    cur_req = "R3";
    clr_meas();
    busy = 1'b1; wait_cyc(4);
    pulse(10, -1, -1);
    wait_cyc(4); busy = 1'b0;
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R3", "blocked width", t0_hi, 0);
    chk_int("R9", "stops after veto", cs_rises, 0);

    // R3: busy falls mid-pulse, no late pulse
    clr_meas();
    busy = 1'b1; wait_cyc(4);
    pulse(12, -1, 5);
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R3", "late partial width", t0_hi, 0);
    chk_int("R9", "stops after late clear", cs_rises, 0);

    // R4: busy rises mid-pulse, truncated
    cur_req = "R4";
    clr_meas();
    pulse(12, 5, -1);
    wait_cyc(6); busy = 1'b0;
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R4", "truncated width", t0_hi, 5);
    chk_int("R4", "stops after truncated", cs_rises, 1);

    // R4: busy pulses inside the trigger, no resume
    clr_meas();
    pulse(12, 4, 7);
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R4", "no resume width", t0_hi, 4);
    chk_int("R4", "no resume rises", t0_rises, 1);

    // R5: burst with busy over the middle
    cur_req = "R5";
    clr_meas();
    for (int k = 0; k < 6; k++) begin
      if (k == 2) busy = 1'b1;
      if (k == 5) busy = 1'b0;
      wait_cyc(3);
      pulse(4, -1, -1);
    end
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R5", "burst forwarded", t0_rises, 3);

    // R8: second trigger 799 cycles later, inside the window
    cur_req = "R8";
    clr_meas();
    pulse(3, -1, -1);
    wait_cyc(WIN - 1 - 4);
    pulse(3, -1, -1);
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R8", "t0 rises at 799", t0_rises, 2);
    chk_int("R8", "stops at 799", cs_rises, 1);

    // R8: second trigger exactly 800 cycles later, new window
    clr_meas();
    pulse(3, -1, -1);
    wait_cyc(WIN - 4);
    pulse(3, -1, -1);
    wait_cyc(1200);
    @(posedge clk);
    chk_int("R8", "t0 rises at 800", t0_rises, 2);
    chk_int("R8", "stops at 800", cs_rises, 2);

    // Random mix, checked cycle by cycle against the model
    cur_req = "R5";
    for (int n = 0; n < 200; n++) begin
      int gap, len;
      gap = $urandom_range(300, 1);
      len = $urandom_range(20, 1);
      for (int i = 0; i < gap; i++) begin
        @(negedge clk);
        if ($urandom_range(15, 0) == 0) busy = ~busy;
      end
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        trig = 1'b1;
        if ($urandom_range(7, 0) == 0) busy = ~busy;
      end
      @(negedge clk);
      trig = 1'b0;
    end
    busy = 1'b0;
    wait_cyc(1200);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule